// File: doc/BRIEF.md
# Serial Channel Interrupt Controller

This block produces the interrupt request, the interrupt vector and the DMA ready strobes for a single serial channel. The channel's receiver tells it when a character arrives, with four error flags, and whether characters are still waiting. The transmitter reports each time its buffer empties. The modem control inputs, a break/abort indicator and an underrun/end-of-message pulse feed a separate external-status source. A control byte selects which sources may interrupt and how the receiver interrupts: not at all, on the first character only, or on every character. The control byte also enables each ready strobe and selects whether the vector carries the source in its low bits.

The host writes the control byte and the vector base. It issues short command codes to acknowledge or clear sources and to reset the channel. It pulses a read line to capture the vector at the start of an acknowledge or read cycle. In first-character mode, a character that arrives with an error sets a hold output, which freezes the receive FIFO outside the block until the host clears the errors. The two ready outputs are active-low strobes of fixed width that start on each transfer event.

Top module: `sio_irq_ctl`

## Requirements
- R1: After hardware reset, `irq` is 0, both ready strobes are high, `rx_hold` and both sticky error outputs are 0, the control byte is 0x00, and a vector read returns 0x0F.
- R2: When control bit 6 is 1, each `tx_empty_stb` drives `txrdy_n` low for exactly 3 clock cycles, starting in the cycle after the strobe. When bit 6 is 0, `txrdy_n` stays high.
- R3: When control bit 5 is 1, each `char_stb` drives `rxrdy_n` low for 3 cycles. The exception is a character with any error flag while the receive mode is first-character: it gives no strobe. When bit 5 is 0, `rxrdy_n` stays high.
- R4: A trigger that arrives while its strobe is low is remembered. After the current pulse ends, the output is high for one cycle, and then a second 3-cycle pulse follows.
- R5: The receive mode is control bits [3:2]: 00 off, 01 first-character, 10 every-character, and 11 also every-character. When the mode is off, there is no receive or special request. In every-character mode, a receive request is present while `rx_avail` is 1. In first-character mode, a receive request is present only while `rx_avail` is 1 and the mode is armed. The mode is armed on entry to first-character mode and by command 5 (re-arm), and disarmed by command 4 (receive acknowledge).
- R6: `rx_err` is {overrun, framing, end-of-frame, parity}, from bit 3 down to bit 0. It is latched on `char_stb` and cleared only by command 1 (error reset) or a reset; `sticky_ovr` and `sticky_par` show two of these bits. Any latched error gives a special request while the mode is not off.
- R7: An errored character in first-character mode sets `rx_hold` until command 1. In every-character mode, `rx_hold` is never set.
- R8: If a source's enable is turned on while its condition is already pending, `irq` rises in the cycle after the control write.
- R9: A pulse on `vec_rd` captures the vector into `vec_out`, which is valid in the next cycle. With control bit 4 at 0, the captured value is the vector register. With bit 4 at 1 and a request active, the low 2 bits are replaced by the highest active source: special 11, receive 10, transmit 01, external 00. Priority follows the same order, special first.
- R10: When control bit 0 is 1, an external request is raised by any edge on a `modem_n` line, by the end of a break (a falling `brk_abort`), or by `eom_set`. Command 2 clears it.
- R11: `tx_empty_stb` sets a transmit pending flag, and command 3 clears it. A transmit request is present while the flag is set and control bit 1 is 1.
- R12: Command 6 (channel reset) clears the control byte, all pending and latched conditions and both strobes. The vector register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_data | input | 7 | Control byte value |
| vec_wr | input | 1 | Write strobe for the vector register |
| vec_data | input | VEC_W | Vector register value |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (1 to 6) |
| char_stb | input | 1 | A character entered the receive FIFO |
| rx_err | input | 4 | Error flags that go with `char_stb` |
| rx_avail | input | 1 | Receive FIFO holds at least one character |
| tx_empty_stb | input | 1 | Transmit buffer became empty |
| modem_n | input | NUM_LINES | Modem and sync input levels |
| brk_abort | input | 1 | Break/abort condition level |
| eom_set | input | 1 | Underrun/end-of-message latch set |
| vec_rd | input | 1 | Start of a vector read or acknowledge |
| irq | output | 1 | Interrupt request |
| vec_out | output | VEC_W | Captured vector |
| txrdy_n | output | 1 | Transmit DMA ready strobe, active low |
| rxrdy_n | output | 1 | Receive DMA ready strobe, active low |
| rx_hold | output | 1 | Freeze request for the receive FIFO |
| sticky_ovr | output | 1 | Latched overrun error |
| sticky_par | output | 1 | Latched parity error |

## Verification
The bench drives characters in three ways: clean, with a parity error in first-character mode, and with an overrun or framing error in the other modes. Comparing these cases shows the strobe being suppressed, the FIFO hold, and the request with the receiver off. Vector reads are made with a special, receive, transmit or external source pending, in combinations of two. These reads separate the priority order from a fixed vector. Strobe triggers are given both alone and while a pulse is already running, which tests the exact width, the one-cycle gap and the queued second pulse.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    typedef enum logic [1:0] {
        RXM_OFF     = 2'd0,
        RXM_FIRST   = 2'd1,
        RXM_ALL     = 2'd2,
        RXM_ALL_ALT = 2'd3
    } rx_mode_e;

    typedef struct packed {
        logic     txrdy_en;
        logic     rxrdy_en;
        logic     sav;
        rx_mode_e rx_mode;
        logic     tx_ie;
        logic     ext_en;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic eof;
        logic par;
    } rx_err_t;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_ERR_RST  = 3'd1,
        CMD_EXT_RST  = 3'd2,
        CMD_TX_ACK   = 3'd3,
        CMD_RX_ACK   = 3'd4,
        CMD_REARM    = 3'd5,
        CMD_CHAN_RST = 3'd6
    } cmd_e;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int ERR_W    = $bits(rx_err_t);
    localparam int NUM_SRC  = 4;
    localparam int SRC_EXT  = 0;
    localparam int SRC_TX   = 1;
    localparam int SRC_RX   = 2;
    localparam int SRC_SPEC = 3;

endpackage

// File: rtl/sio_rdy_strobe.sv
module sio_rdy_strobe #(
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic trig,
    output logic strobe_n
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } st_t;

    st_t  st_q, st_d;
    logic fire;

    always_comb begin
        st_d = st_q;
        fire = en && trig;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (fire) begin
                st_d.pend = 1'b1;
            end
        end else if (fire || st_q.pend) begin
            st_d.cnt  = CW'(PULSE_LEN);
            st_d.pend = 1'b0;
        end
        if (clr || !en) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_n = !(en && (st_q.cnt != '0));

endmodule

// File: rtl/sio_ext_detect.sv
module sio_ext_detect #(
    parameter int NUM_LINES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_LINES-1:0] lines_n,
    input  logic                 brk,
    input  logic                 eom_set,
    output logic                 pend
);
    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic                 brk_prev;
        logic                 vld;
        logic                 pend;
    } st_t;

    st_t                  st_q, st_d;
    logic [NUM_LINES-1:0] line_edge;
    logic                 brk_end;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign line_edge[i] = st_q.vld && (lines_n[i] != st_q.prev[i]);
    end

    assign brk_end = st_q.brk_prev && !brk;

    always_comb begin
        st_d          = st_q;
        st_d.prev     = lines_n;
        st_d.brk_prev = brk;
        st_d.vld      = 1'b1;
        if (clr) begin
            st_d.pend = 1'b0;
        end
        if ((|line_edge) || brk_end || eom_set) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec #(
    parameter int VEC_W   = 8,
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [VEC_W-1:0]   base,
    input  logic               sav,
    output logic               any,
    output logic [VEC_W-1:0]   vec
);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic [SRC_W-1:0] code;

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                code = SRC_W'(i);
            end
        end
        any = |req;
        vec = (sav && any) ? {base[VEC_W-1:SRC_W], code} : base;
    end

endmodule

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl
    import sio_irq_pkg::*;
#(
    parameter int              VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_RESET = 8'h0F,
    parameter int              PULSE_LEN = 3,
    parameter int              NUM_LINES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [6:0]           cfg_data,
    input  logic                 vec_wr,
    input  logic [VEC_W-1:0]     vec_data,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_code,
    input  logic                 char_stb,
    input  logic [3:0]           rx_err,
    input  logic                 rx_avail,
    input  logic                 tx_empty_stb,
    input  logic [NUM_LINES-1:0] modem_n,
    input  logic                 brk_abort,
    input  logic                 eom_set,
    input  logic                 vec_rd,
    output logic                 irq,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 txrdy_n,
    output logic                 rxrdy_n,
    output logic                 rx_hold,
    output logic                 sticky_ovr,
    output logic                 sticky_par
);
    localparam int NUM_STB = 2;
    localparam int STB_TX  = 0;
    localparam int STB_RX  = 1;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [VEC_W-1:0]  vec_reg;
        logic [VEC_W-1:0]  vec_cap;
        rx_err_t           err;
        logic              hold;
        logic              armed;
        logic              tx_pend;
    } st_t;

    st_t                st_q, st_d;
    ctrl_t              cfg_in;
    rx_err_t            err_in;
    logic               c_err, c_ext, c_txack, c_rxack, c_rearm, c_chan;
    logic               mode_first, mode_all, mode_on;
    logic               err_any;
    logic [NUM_SRC-1:0] req;
    logic               req_any;
    logic [VEC_W-1:0]   vec_mux;
    logic               ext_pend;
    logic [NUM_STB-1:0] stb_en, stb_trig, stb_n;

    assign cfg_in  = ctrl_t'(cfg_data);
    assign err_in  = rx_err_t'(rx_err);
    assign err_any = |rx_err;

    assign c_err   = cmd_valid && (cmd_code == CMD_ERR_RST);
    assign c_ext   = cmd_valid && (cmd_code == CMD_EXT_RST);
    assign c_txack = cmd_valid && (cmd_code == CMD_TX_ACK);
    assign c_rxack = cmd_valid && (cmd_code == CMD_RX_ACK);
    assign c_rearm = cmd_valid && (cmd_code == CMD_REARM);
    assign c_chan  = cmd_valid && (cmd_code == CMD_CHAN_RST);

    assign mode_first = (st_q.ctrl.rx_mode == RXM_FIRST);
    assign mode_all   = (st_q.ctrl.rx_mode == RXM_ALL) || (st_q.ctrl.rx_mode == RXM_ALL_ALT);
    assign mode_on    = (st_q.ctrl.rx_mode != RXM_OFF);

    // request vector, index = source code
    assign req[SRC_SPEC] = mode_on && (|st_q.err);
    assign req[SRC_RX]   = rx_avail && (mode_all || (mode_first && st_q.armed));
    assign req[SRC_TX]   = st_q.ctrl.tx_ie && st_q.tx_pend;
    assign req[SRC_EXT]  = st_q.ctrl.ext_en && ext_pend;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.ctrl = cfg_in;
            if ((cfg_in.rx_mode == RXM_FIRST) && !mode_first) begin
                st_d.armed = 1'b1;
            end
        end
        if (vec_wr) begin
            st_d.vec_reg = vec_data;
        end
        if (c_err) begin
            st_d.err  = '0;
            st_d.hold = 1'b0;
        end
        if (char_stb) begin
            st_d.err = st_q.err & {ERR_W{!c_err}};
            st_d.err = st_d.err | err_in;
            if (mode_first && err_any) begin
                st_d.hold = 1'b1;
            end
        end
        if (c_rxack) begin
            st_d.armed = 1'b0;
        end
        if (c_rearm) begin
            st_d.armed = 1'b1;
        end
        if (c_txack) begin
            st_d.tx_pend = 1'b0;
        end
        if (tx_empty_stb) begin
            st_d.tx_pend = 1'b1;
        end
        if (vec_rd) begin
            st_d.vec_cap = vec_mux;
        end
        if (c_chan) begin
            st_d.ctrl    = '0;
            st_d.err     = '0;
            st_d.hold    = 1'b0;
            st_d.armed   = 1'b0;
            st_d.tx_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.vec_reg <= VEC_RESET;
            st_q.vec_cap <= VEC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    sio_ext_detect #(
        .NUM_LINES (NUM_LINES)
    ) ext_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (c_ext || c_chan),
        .lines_n (modem_n),
        .brk     (brk_abort),
        .eom_set (eom_set),
        .pend    (ext_pend)
    );

    sio_irq_vec #(
        .VEC_W   (VEC_W),
        .NUM_SRC (NUM_SRC)
    ) vec_i (
        .req  (req),
        .base (st_q.vec_reg),
        .sav  (st_q.ctrl.sav),
        .any  (req_any),
        .vec  (vec_mux)
    );

    assign stb_en[STB_TX]   = st_q.ctrl.txrdy_en;
    assign stb_trig[STB_TX] = tx_empty_stb;
    assign stb_en[STB_RX]   = st_q.ctrl.rxrdy_en;
    assign stb_trig[STB_RX] = char_stb && !(mode_first && err_any);

    for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
        sio_rdy_strobe #(
            .PULSE_LEN (PULSE_LEN)
        ) stb_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (c_chan),
            .en       (stb_en[s]),
            .trig     (stb_trig[s]),
            .strobe_n (stb_n[s])
        );
    end

    assign irq        = req_any;
    assign vec_out    = st_q.vec_cap;
    assign txrdy_n    = stb_n[STB_TX];
    assign rxrdy_n    = stb_n[STB_RX];
    assign rx_hold    = st_q.hold;
    assign sticky_ovr = st_q.err.ovr;
    assign sticky_par = st_q.err.par;

endmodule

// File: rtl/sio_irq_ctl_chk.sv
module sio_irq_ctl_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       ctrl_bits,
    input logic [VEC_W-1:0] vec_reg,
    input logic             cmd_valid,
    input logic [2:0]       cmd_code,
    input logic             char_stb,
    input logic             vec_rd,
    input logic             vec_wr,
    input logic             irq,
    input logic [VEC_W-1:0] vec_out,
    input logic             txrdy_n,
    input logic             rxrdy_n,
    input logic             rx_hold,
    input logic             sticky_ovr,
    input logic             sticky_par
);

    assert_txrdy_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txrdy_n) |=> (!txrdy_n || !ctrl_bits[6]));

    assert_rxrdy_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxrdy_n) |=> (!rxrdy_n || !ctrl_bits[5]));

    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_bits[3:2] == 2'b00) && !ctrl_bits[1] && !ctrl_bits[0]) |-> !irq);

    assert_err_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == 3'd1) && !char_stb) |=> (!sticky_ovr && !sticky_par && !rx_hold));

    assert_hold_first_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_hold) |-> $past(ctrl_bits[3:2] == 2'b01));

    assert_fixed_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !ctrl_bits[4] && !vec_wr) |=> (vec_out == $past(vec_reg)));

    assert_chan_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == 3'd6)) |=> (!irq && txrdy_n && rxrdy_n && (ctrl_bits == 7'd0)));

endmodule

bind sio_irq_ctl sio_irq_ctl_chk #(.VEC_W(VEC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_bits  (st_q.ctrl),
    .vec_reg    (st_q.vec_reg),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .char_stb   (char_stb),
    .vec_rd     (vec_rd),
    .vec_wr     (vec_wr),
    .irq        (irq),
    .vec_out    (vec_out),
    .txrdy_n    (txrdy_n),
    .rxrdy_n    (rxrdy_n),
    .rx_hold    (rx_hold),
    .sticky_ovr (sticky_ovr),
    .sticky_par (sticky_par)
);

// File: tb/sio_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module sio_irq_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_data = '0;
    logic       vec_wr = 1'b0;
    logic [7:0] vec_data = '0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = '0;
    logic       char_stb = 1'b0;
    logic [3:0] rx_err = '0;
    logic       rx_avail = 1'b0;
    logic       tx_empty_stb = 1'b0;
    logic [2:0] modem_n = 3'b111;
    logic       brk_abort = 1'b0;
    logic       eom_set = 1'b0;
    logic       vec_rd = 1'b0;
    logic       irq, txrdy_n, rxrdy_n, rx_hold, sticky_ovr, sticky_par;
    logic [7:0] vec_out;

    int   total = 0;
    int   bad = 0;
    logic done = 1'b0;
    logic rd_d = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    sio_irq_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .vec_wr(vec_wr), .vec_data(vec_data), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .char_stb(char_stb), .rx_err(rx_err),
        .rx_avail(rx_avail), .tx_empty_stb(tx_empty_stb), .modem_n(modem_n),
        .brk_abort(brk_abort), .eom_set(eom_set), .vec_rd(vec_rd),
        .irq(irq), .vec_out(vec_out), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
        .rx_hold(rx_hold), .sticky_ovr(sticky_ovr), .sticky_par(sticky_par)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [6:0] v);
        cfg_wr = 1'b1; cfg_data = v; tick(); cfg_wr = 1'b0;
    endtask

    task automatic write_vec(input logic [7:0] v);
        vec_wr = 1'b1; vec_data = v; tick(); vec_wr = 1'b0;
    endtask

    task automatic command(input logic [2:0] c);
        cmd_valid = 1'b1; cmd_code = c; tick(); cmd_valid = 1'b0; cmd_code = '0;
    endtask

    task automatic pulse_tx();
        tx_empty_stb = 1'b1; tick(); tx_empty_stb = 1'b0;
    endtask

    task automatic pulse_char(input logic [3:0] e);
        char_stb = 1'b1; rx_err = e; tick(); char_stb = 1'b0; rx_err = '0;
    endtask

    // driver side of the scoreboard
    task automatic read_vec(input logic [7:0] exp, input string req);
        item_t it;
        it.req = req; it.exp = exp;
        sb_q.push_back(it);
        vec_rd = 1'b1; tick(); vec_rd = 1'b0;
    endtask

    // monitor side of the scoreboard
    always @(posedge clk) rd_d <= vec_rd;

    always @(negedge clk) begin
        if (rd_d) begin
            if (sb_q.size() == 0) begin
                chk("R9 unexpected vector read", 32'(vec_out), 32'hFFFF);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.req, 32'(vec_out), 32'(it.exp));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 txrdy_n", 32'(txrdy_n), 1);
        chk("R1 rxrdy_n", 32'(rxrdy_n), 1);
        chk("R1 rx_hold", 32'(rx_hold), 0);
        chk("R1 sticky", 32'({sticky_ovr, sticky_par}), 0);
        read_vec(8'h0F, "R1 reset vector");

        // R2 strobe disabled, R11 pending without enable
        pulse_tx();
        chk("R2 disabled n1", 32'(txrdy_n), 1);
        tick(); chk("R2 disabled n2", 32'(txrdy_n), 1);
        tick(); chk("R2 disabled n3", 32'(txrdy_n), 1);
        chk("R11 no tx_ie", 32'(irq), 0);
        write_ctrl(7'h02);
        chk("R8 tx enable while pending", 32'(irq), 1);
        write_ctrl(7'h12);
        read_vec(8'h0D, "R9 tx code on reset base");
        command(3'd3);
        chk("R11 tx ack", 32'(irq), 0);
        write_vec(8'hA0);
        write_ctrl(7'h00);
        read_vec(8'hA0, "R9 fixed vector");

        // R2 enabled width
        write_ctrl(7'h40);
        pulse_tx();
        chk("R2 low c1", 32'(txrdy_n), 0);
        tick(); chk("R2 low c2", 32'(txrdy_n), 0);
        tick(); chk("R2 low c3", 32'(txrdy_n), 0);
        tick(); chk("R2 high after", 32'(txrdy_n), 1);
        command(3'd3);

        // R4 retrigger on receive strobe
        write_ctrl(7'h20);
        pulse_char(4'b0000);
        chk("R4 first c1", 32'(rxrdy_n), 0);
        char_stb = 1'b1; tick(); char_stb = 1'b0;
        chk("R4 first c2", 32'(rxrdy_n), 0);
        tick(); chk("R4 first c3", 32'(rxrdy_n), 0);
        tick(); chk("R4 gap", 32'(rxrdy_n), 1);
        tick(); chk("R4 second c1", 32'(rxrdy_n), 0);
        tick(); chk("R4 second c2", 32'(rxrdy_n), 0);
        tick(); chk("R4 second c3", 32'(rxrdy_n), 0);
        tick(); chk("R4 end", 32'(rxrdy_n), 1);

        // R5 first-character mode, R3 suppression, R7 hold
        write_ctrl(7'h24);
        rx_avail = 1'b1; tick();
        chk("R5 first armed", 32'(irq), 1);
        pulse_char(4'b0001);
        chk("R3 no strobe c1", 32'(rxrdy_n), 1);
        tick(); chk("R3 no strobe c2", 32'(rxrdy_n), 1);
        tick(); chk("R3 no strobe c3", 32'(rxrdy_n), 1);
        chk("R7 hold set", 32'(rx_hold), 1);
        chk("R6 parity sticky", 32'(sticky_par), 1);
        write_ctrl(7'h34);
        read_vec(8'hA3, "R9 special over receive");
        command(3'd1);
        chk("R7 hold cleared", 32'(rx_hold), 0);
        chk("R6 parity cleared", 32'(sticky_par), 0);
        read_vec(8'hA2, "R9 receive code");
        command(3'd4);
        chk("R5 first disarmed", 32'(irq), 0);
        pulse_char(4'b0000);
        chk("R3 strobe c1", 32'(rxrdy_n), 0);
        tick(); chk("R3 strobe c2", 32'(rxrdy_n), 0);
        tick(); chk("R3 strobe c3", 32'(rxrdy_n), 0);
        tick(); chk("R3 strobe end", 32'(rxrdy_n), 1);
        chk("R5 no second request", 32'(irq), 0);
        command(3'd5);
        chk("R5 rearm", 32'(irq), 1);
        rx_avail = 1'b0; tick();
        chk("R5 fifo empty", 32'(irq), 0);

        // R7 every-character mode
        write_ctrl(7'h08);
        pulse_char(4'b1000);
        chk("R7 no hold every mode", 32'(rx_hold), 0);
        chk("R6 overrun sticky", 32'(sticky_ovr), 1);
        chk("R6 special request", 32'(irq), 1);
        tick(); tick();
        chk("R6 overrun still set", 32'(sticky_ovr), 1);
        command(3'd1);
        chk("R6 overrun cleared", 32'(sticky_ovr), 0);
        chk("R6 request cleared", 32'(irq), 0);
        rx_avail = 1'b1; tick();
        chk("R5 every char level", 32'(irq), 1);
        rx_avail = 1'b0; tick();
        chk("R5 every char empty", 32'(irq), 0);
        write_ctrl(7'h0C);
        rx_avail = 1'b1; tick();
        chk("R5 mode 11", 32'(irq), 1);
        rx_avail = 1'b0; tick();

        // R5 off mode and R8 enable with pending special
        write_ctrl(7'h00);
        pulse_char(4'b0100);
        tick();
        chk("R5 off no request", 32'(irq), 0);
        write_ctrl(7'h08);
        chk("R8 special pending on enable", 32'(irq), 1);
        command(3'd1);
        chk("R6 framing cleared", 32'(irq), 0);

        // R10 external status
        write_ctrl(7'h11);
        modem_n[0] = 1'b0; tick();
        chk("R10 line edge", 32'(irq), 1);
        read_vec(8'hA0, "R10 external code");
        command(3'd2);
        chk("R10 ext reset", 32'(irq), 0);
        modem_n[2] = 1'b0; tick();
        chk("R10 sync edge", 32'(irq), 1);
        command(3'd2);
        brk_abort = 1'b1; tick(); tick();
        chk("R10 break start", 32'(irq), 0);
        brk_abort = 1'b0; tick();
        chk("R10 break end", 32'(irq), 1);
        command(3'd2);
        eom_set = 1'b1; tick(); eom_set = 1'b0;
        chk("R10 eom", 32'(irq), 1);
        pulse_tx();
        write_ctrl(7'h13);
        read_vec(8'hA1, "R9 transmit over external");
        command(3'd2);
        command(3'd3);
        chk("R11 all cleared", 32'(irq), 0);

        // R12 channel reset
        write_ctrl(7'h7F);
        pulse_tx();
        chk("R12 strobe running", 32'(txrdy_n), 0);
        command(3'd6);
        chk("R12 strobe cut", 32'(txrdy_n), 1);
        chk("R12 irq", 32'(irq), 0);
        read_vec(8'hA0, "R12 vector kept");
        write_ctrl(7'h02);
        chk("R12 tx pending cleared", 32'(irq), 0);

        tick(); tick();
        chk("R9 scoreboard drained", 32'(sb_q.size()), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule